// File: doc/BRIEF.md
# Up-Down PWM Timebase with Direction-Qualified Actions

This block is a single PWM channel with two outputs, A and B, driven by a triangle counter. The counter climbs from zero to a programmable period and falls back to zero. Two compare values decide where the output edges fall, and the count direction at the moment of a match decides which way each output moves. Compare values are written to shadow copies. The counter only picks them up when it passes through zero, so a change never splits a triangle in two.

Each zero of the counter emits a one-cycle sync pulse. Another instance can be wired to use that pulse as its sync input. When phase loading is enabled, that follower jumps its counter to a programmable phase value, which sets up phase-shifted channels. The leader keeps phase loading off.

Counter zeros also feed an event prescaler, which raises a sticky interrupt flag on every Nth zero. A continuous software force holds both outputs low for fault protection and takes priority over every compare action. Configuration is written through a plain single-cycle write strobe.

Top module: `updn_pwm`

Register addresses on the write port:

| Address | Register |
|---|---|
| 0 | period |
| 1 | compare A shadow |
| 2 | compare B shadow |
| 3 | phase value |
| 4 | control |
| 5 | interrupt clear; any write clears the flag |

Control register bit fields:

| Bits | Field | Reset value |
|---|---|---|
| 0 | phase-load enable | parameter |
| 1 | force-low | 0 |
| 5:2 | event prescale count; 0 never raises the flag | 3 |

## Requirements
- R1: While reset is held and in the first sample after its release, pwm_a and pwm_b are 0 and irq is 0. In that first sample the counter is at 0, so sync_out is 1. The counter counts up first.
- R2: The counter runs the sequence 0, 1, …, P, P−1, …, 1, 0, 1, … where P is the period register. sync_out is 1 exactly in the cycles where the counter is 0, which gives one pulse every 2·P cycles.
- R3: A compare A match while counting down sets pwm_a to 1 in the next cycle. A compare B match while counting up clears pwm_a to 0 in the next cycle. Otherwise pwm_a holds its value.
- R4: pwm_b does the opposite on the same two events. It clears to 0 on the down-count compare A match and sets to 1 on the up-count compare B match, one cycle later.
- R5: Writes to addresses 1 and 2 go to shadow registers. The active compare values take the shadow values at the clock edge that ends a cycle in which the counter is 0.
- R6: With control bit 0 set, a cycle with sync_in high loads the phase value into the counter and sets the direction to up, so the next sync_out comes 2·P − phase cycles later. With bit 0 clear, sync_in is ignored.
- R7: Every counter-zero cycle counts as an event, including the first cycle after reset. On the event that brings the count to the prescale value in bits 5:2 (3 after reset), irq is set in the next cycle and the count restarts.
- R8: irq stays at 1 until a write to address 5. If that write falls in the same cycle as the event that sets the flag, the flag ends up set.
- R9: While control bit 1 is 1, both outputs are driven to 0 in the next cycle, ahead of any compare action. After the bit is cleared, the outputs hold 0 until the next compare action.
- R10: Out of reset the period is 1500 and both compares are 50. Over one 3000-cycle triangle, pwm_a is 1 for 100 cycles (about 3.33 %) and pwm_b is 1 for 2900 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Register write data |
| sync_in | input | 1 | Phase-load request from a leader |
| sync_out | output | 1 | High while the counter is at zero |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |
| irq | output | 1 | Sticky prescaled zero-event interrupt flag |

## Verification
The interrupt clear strobe and the prescaled zero event that sets the flag can land on the same clock edge. To provoke this, the bench first clears the flag. It then counts zeros arithmetically from the reset origin and issues the clear write on exactly the edge of the third zero. The case passes only if the flag reads 1 afterwards, because a clear-wins design would leave it at 0. A second overlap is tested as well: a shadow compare write arriving in the middle of a triangle must not change the edge that triangle produces.

// File: rtl/updn_pwm_pkg.sv
package updn_pwm_pkg;
  localparam int ADDR_W = 3;
  localparam int PSC_W  = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_PERIOD = 3'd0,
    RA_CMPA   = 3'd1,
    RA_CMPB   = 3'd2,
    RA_PHASE  = 3'd3,
    RA_CTRL   = 3'd4,
    RA_IRQCLR = 3'd5
  } reg_addr_e;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } cnt_dir_e;

  typedef struct packed {
    logic [PSC_W-1:0] psc;
    logic             force_lo;
    logic             ph_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import updn_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] prd,
  input  logic [CNT_W-1:0] phase,
  input  logic             ld,
  output logic [CNT_W-1:0] cnt,
  output cnt_dir_e         dir,
  output logic             zero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      dir <= DIR_UP;
    end else if (ld) begin
      cnt <= phase;
      dir <= DIR_UP;
    end else if (dir == DIR_UP) begin
      if (cnt >= prd && cnt != '0) begin
        cnt <= cnt - ONE;
        dir <= DIR_DOWN;
      end else begin
        cnt <= cnt + ONE;
      end
    end else begin
      if (cnt == '0) begin
        cnt <= ONE;
        dir <= DIR_UP;
      end else begin
        cnt <= cnt - ONE;
      end
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/pwm_cmp_bank.sv
module pwm_cmp_bank #(
  parameter int              N     = 2,
  parameter int              W     = 16,
  parameter logic [W-1:0]    RST_V = W'(50)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        wr,
  input  logic [W-1:0]        wdata,
  input  logic                zero,
  output logic [N-1:0][W-1:0] act
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic [W-1:0] shd_q;
    logic [W-1:0] act_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd_q <= RST_V;
        act_q <= RST_V;
      end else begin
        if (wr[g]) shd_q <= wdata;
        if (zero)  act_q <= shd_q;
      end
    end

    assign act[g] = act_q;
  end
endmodule

// File: rtl/pwm_action.sv
module pwm_action
  import updn_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CNT_W-1:0]      cnt,
  input  cnt_dir_e              dir,
  input  logic [1:0][CNT_W-1:0] cmp,
  input  logic                  force_lo,
  output logic [1:0]            outs
);
  logic ev_dn_a;
  logic ev_up_b;

  assign ev_dn_a = (dir == DIR_DOWN) && (cnt == cmp[0]);
  assign ev_up_b = (dir == DIR_UP)   && (cnt == cmp[1]);

  for (genvar i = 0; i < 2; i++) begin : g_out
    localparam logic POL = (i == 1);
    logic q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= 1'b0;
      else if (force_lo) q <= 1'b0;
      else if (ev_dn_a) q <= ~POL;
      else if (ev_up_b) q <= POL;
    end

    assign outs[i] = q;
  end
endmodule

// File: rtl/pwm_evt_irq.sv
module pwm_evt_irq #(
  parameter int PSC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zero,
  input  logic [PSC_W-1:0] psc,
  input  logic             clr,
  output logic             irq
);
  logic [PSC_W-1:0] ev_q;
  logic [PSC_W:0]   ev_nx;
  logic             fire;

  assign ev_nx = {1'b0, ev_q} + 1'b1;
  assign fire  = zero && (psc != '0) && (ev_nx >= {1'b0, psc});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q <= '0;
      irq  <= 1'b0;
    end else begin
      if (zero) ev_q <= fire ? '0 : ev_nx[PSC_W-1:0];
      if (fire)     irq <= 1'b1;
      else if (clr) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/updn_pwm.sv
module updn_pwm
  import updn_pwm_pkg::*;
#(
  parameter int   CNT_W     = 16,
  parameter int   PRD_RST   = 1500,
  parameter int   CMP_RST   = 50,
  parameter int   PSC_RST   = 3,
  parameter logic PH_EN_RST = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             sync_in,
  output logic             sync_out,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic             irq
);
  logic [CNT_W-1:0]      prd_q;
  logic [CNT_W-1:0]      phase_q;
  ctrl_t                 ctrl_q;
  logic [CNT_W-1:0]      cnt_w;
  cnt_dir_e              dir_w;
  logic                  zero_w;
  logic                  ld_w;
  logic                  irq_clr;
  logic [1:0]            cmp_wr;
  logic [1:0][CNT_W-1:0] cmp_act;
  logic [1:0]            outs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_q   <= CNT_W'(PRD_RST);
      phase_q <= '0;
      ctrl_q  <= '{psc: PSC_W'(PSC_RST), force_lo: 1'b0, ph_en: PH_EN_RST};
    end else if (wr_en) begin
      case (wr_addr)
        RA_PERIOD: prd_q   <= wr_data;
        RA_PHASE:  phase_q <= wr_data;
        RA_CTRL:   ctrl_q  <= ctrl_t'(wr_data[CTRL_W-1:0]);
        default:   ;
      endcase
    end
  end

  assign cmp_wr[0] = wr_en && (wr_addr == RA_CMPA);
  assign cmp_wr[1] = wr_en && (wr_addr == RA_CMPB);
  assign irq_clr   = wr_en && (wr_addr == RA_IRQCLR);
  assign ld_w      = sync_in && ctrl_q.ph_en;

  pwm_timebase #(.CNT_W(CNT_W)) tb_i (
    .clk(clk), .rst_n(rst_n), .prd(prd_q), .phase(phase_q), .ld(ld_w),
    .cnt(cnt_w), .dir(dir_w), .zero(zero_w)
  );

  pwm_cmp_bank #(.N(2), .W(CNT_W), .RST_V(CNT_W'(CMP_RST))) cmp_i (
    .clk(clk), .rst_n(rst_n), .wr(cmp_wr), .wdata(wr_data), .zero(zero_w),
    .act(cmp_act)
  );

  pwm_action #(.CNT_W(CNT_W)) aq_i (
    .clk(clk), .rst_n(rst_n), .cnt(cnt_w), .dir(dir_w), .cmp(cmp_act),
    .force_lo(ctrl_q.force_lo), .outs(outs)
  );

  pwm_evt_irq #(.PSC_W(PSC_W)) evt_i (
    .clk(clk), .rst_n(rst_n), .zero(zero_w), .psc(ctrl_q.psc),
    .clr(irq_clr), .irq(irq)
  );

  assign sync_out = zero_w;
  assign pwm_a    = outs[0];
  assign pwm_b    = outs[1];
endmodule

// File: rtl/updn_pwm_sva.sv
module updn_pwm_sva #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld,
  input logic             dir,
  input logic             force_lo,
  input logic             irq_clr,
  input logic             sync_out,
  input logic             pwm_a,
  input logic             pwm_b,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp_a,
  input logic [CNT_W-1:0] cmp_b
);
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> ((cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1))); // R2

  AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_out && !ld) |=> !sync_out); // R2

  AST_A_RISE_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_a) |-> ($past(cnt) == $past(cmp_a) && !$past(dir))); // R3

  AST_B_RISE_UP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_b) |-> ($past(cnt) == $past(cmp_b) && $past(dir))); // R4

  AST_CMP_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_out |=> $stable(cmp_a)); // R5

  AST_CMP_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_out |=> $stable(cmp_b)); // R5

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq); // R8

  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    force_lo |=> (!pwm_a && !pwm_b)); // R9
endmodule

bind updn_pwm updn_pwm_sva #(.CNT_W(CNT_W)) sva_i (
  .clk(clk), .rst_n(rst_n), .ld(ld_w), .dir(dir_w), .force_lo(ctrl_q.force_lo),
  .irq_clr(irq_clr), .sync_out(sync_out), .pwm_a(pwm_a), .pwm_b(pwm_b),
  .irq(irq), .cnt(cnt_w), .cmp_a(cmp_act[0]), .cmp_b(cmp_act[1])
);

// File: tb/updn_pwm_tb_top.sv
module updn_pwm_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        sync_in = 1'b0;
  logic        sync_out, pwm_a, pwm_b, irq;

  int  s = 0;
  int  n_tests = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  updn_pwm dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sync_in(sync_in), .sync_out(sync_out),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .irq(irq)
  );

  task automatic tick();
    @(negedge clk);
    s++;
  endtask

  task automatic run_to(input int t);
    while (s < t) tick();
  endtask

  task automatic wr(input int a, input int d);
    wr_en   = 1'b1;
    wr_addr = 3'(a);
    wr_data = 16'(d);
    tick();
    wr_en   = 1'b0;
  endtask

  task automatic origin();
    sync_in = 1'b1;
    tick();
    sync_in = 1'b0;
    s = 0;
  endtask

  function automatic int ctrl_word(input int phen, input int frc, input int psc);
    return (psc << 2) | (frc << 1) | phen;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int tri_cnt(input int k, input int p);
    int m;
    m = k % (2 * p);
    return (m <= p) ? m : 2 * p - m;
  endfunction

  function automatic bit tri_up(input int k, input int p);
    return (k % (2 * p)) < p;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int ca_l[3];
    int cb_l[3];
    int cnt_a, cnt_b;
    ca_l = '{2, 5, 8};
    cb_l = '{1, 4, 9};

    // R1: reset state
    tick(); tick();
    check("R1 pwm_a in reset", int'(pwm_a), 0);
    rst_n = 1'b1;
    s = 0;
    check("R1 pwm_a after reset", int'(pwm_a), 0);
    check("R1 pwm_b after reset", int'(pwm_b), 0);
    check("R1 irq after reset", int'(irq), 0);
    check("R1 sync_out at origin", int'(sync_out), 1);

    // R10: default period 1500, compares 50
    cnt_a = 0; cnt_b = 0;
    while (s < 4500) begin
      if (s >= 1500) begin
        cnt_a += int'(pwm_a);
        cnt_b += int'(pwm_b);
      end
      if (s == 2999) check("R10 sync_out before zero", int'(sync_out), 0);
      if (s == 3000) check("R10 sync_out at 2P", int'(sync_out), 1);
      tick();
    end
    check("R10 pwm_a high cycles", cnt_a, 100);
    check("R10 pwm_b high cycles", cnt_b, 2900);

    // small configuration, period 10
    wr(0, 10);
    wr(3, 0);
    wr(4, ctrl_word(1, 0, 3));

    // R2, R3, R4 sweep over compare pairs
    for (int ia = 0; ia < 3; ia++) begin
      for (int ib = 0; ib < 3; ib++) begin
        int  ca, cb, ma, mb, ms, c;
        bit  known, ea, eb, u;
        ca = ca_l[ia]; cb = cb_l[ib];
        ma = 0; mb = 0; ms = 0; known = 1'b0; ea = 1'b0; eb = 1'b0;
        wr(1, ca);
        wr(2, cb);
        origin();
        for (int k = 0; k < 60; k++) begin
          if (k > 0) begin
            c = tri_cnt(k - 1, 10);
            u = tri_up(k - 1, 10);
            if (!u && c == ca) begin ea = 1'b1; eb = 1'b0; known = 1'b1; end
            else if (u && c == cb) begin ea = 1'b0; eb = 1'b1; known = 1'b1; end
          end
          if (known && pwm_a != ea) ma++;
          if (known && pwm_b != eb) mb++;
          if (sync_out != ((k % 20) == 0)) ms++;
          tick();
        end
        check($sformatf("R3 pwm_a mismatches ca=%0d cb=%0d", ca, cb), ma, 0);
        check($sformatf("R4 pwm_b mismatches ca=%0d cb=%0d", ca, cb), mb, 0);
        check($sformatf("R2 sync_out mismatches ca=%0d cb=%0d", ca, cb), ms, 0);
      end
    end

    // R9: software force low
    wr(1, 3);
    wr(2, 6);
    origin();
    run_to(20);
    check("R9 pwm_a high before force", int'(pwm_a), 1);
    wr(4, ctrl_word(1, 1, 3));
    check("R9 pwm_a one cycle after force write", int'(pwm_a), 1);
    run_to(22);
    check("R9 pwm_a forced low", int'(pwm_a), 0);
    run_to(28);
    check("R9 pwm_b stays low over up match", int'(pwm_b), 0);
    run_to(30);
    wr(4, ctrl_word(1, 0, 3));
    run_to(36);
    check("R9 pwm_a holds low after release", int'(pwm_a), 0);
    check("R9 pwm_b holds low after release", int'(pwm_b), 0);
    run_to(38);
    check("R9 pwm_a resumes on down match", int'(pwm_a), 1);

    // R5: shadow compare loads only at zero
    origin();
    run_to(22);
    wr(2, 8);
    run_to(26);
    check("R5 pwm_a before old compare B edge", int'(pwm_a), 1);
    run_to(27);
    check("R5 old compare B still active", int'(pwm_a), 0);
    run_to(48);
    check("R5 pwm_a before new compare B edge", int'(pwm_a), 1);
    run_to(49);
    check("R5 new compare B after zero", int'(pwm_a), 0);

    // R6: phase load and ignore when disabled
    wr(3, 4);
    origin();
    run_to(15);
    check("R6 sync_out before 2P-phase", int'(sync_out), 0);
    run_to(16);
    check("R6 sync_out at 2P-phase", int'(sync_out), 1);
    wr(3, 0);
    origin();
    wr(4, ctrl_word(0, 0, 3));
    wr(3, 4);
    run_to(5);
    sync_in = 1'b1;
    tick();
    sync_in = 1'b0;
    run_to(19);
    check("R6 ignored sync, no early zero", int'(sync_out), 0);
    run_to(20);
    check("R6 ignored sync, zero at 2P", int'(sync_out), 1);

    // R7, R8: interrupt prescale and sticky flag
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    s = 0;
    run_to(6000);
    check("R7 irq before third zero", int'(irq), 0);
    run_to(6001);
    check("R7 irq after third zero", int'(irq), 1);
    run_to(6500);
    check("R8 irq sticky", int'(irq), 1);
    run_to(6600);
    wr(5, 0);
    check("R8 irq cleared", int'(irq), 0);
    run_to(12001);
    check("R7 irq not on second zero", int'(irq), 0);
    run_to(15000);
    wr(5, 0);
    check("R8 set wins over coincident clear", int'(irq), 1);
    wr(4, ctrl_word(0, 0, 1));
    run_to(17000);
    wr(5, 0);
    check("R8 irq cleared again", int'(irq), 0);
    run_to(18001);
    check("R7 prescale 1 sets on every zero", int'(irq), 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule